// File: doc/BRIEF.md
# Shared-Bus Converter Follower Sequencer

This block reproduces an analog input at an analog output by moving samples from an input converter (ADC) to an output converter (DAC) over one shared SPI bus. It runs two phases in turn. First it selects the ADC and shifts one sample in on MISO. Then it selects the DAC and shifts out a frame whose low bits carry that sample. The output is therefore a quantized, delayed copy of the input.

Both devices share SCLK, MOSI and MISO. Each device has its own active-low select. The bus runs in SPI mode 0. SCLK is derived from the system clock by an even divider, and one rate serves both devices. On every change of owner the block inserts an idle stretch of whole SPI clock periods. During that stretch both selects are high and SCLK is low, so the device being released has time to float its output before the other device is selected.

While `enable_i` is high the pair of phases repeats without end. When `enable_i` drops, the frame in flight completes and the block comes to rest.

Top module: `spi_follower`

## Requirements
- R1: While enabled, frames alternate in the order ADC frame, then DAC frame. A DAC select is never asserted unless the select asserted before it was the ADC's.
- R2: The two chip selects are never low in the same cycle.
- R3: Timing of SCLK and the data lines:
  - SCLK idles low.
  - Within a frame, consecutive rising SCLK edges are CLK_DIV system cycles apart.
  - The first rising edge comes CLK_DIV/2 cycles after the select falls.
  - MISO is sampled on rising edges, and MOSI changes only after falling edges.
- R4: Between any select rising and the next select falling, both selects stay high and SCLK stays low for at least GAP_CLKS*CLK_DIV system cycles.
- R5: An ADC frame has exactly ADC_W rising SCLK edges and reads MSB first. `sample_o` then takes the value read.
- R6: A DAC frame has exactly DAC_W rising SCLK edges. It carries, MSB first, the word {DAC_CMD, most recent ADC sample}, with the sample in the low ADC_W bits.
- R7: `sample_valid_o` is high for exactly one cycle. That cycle is the first cycle in which the ADC select is high after an ADC frame.
- R8: `dac_done_o` is high for exactly one cycle. That cycle is the first cycle in which the DAC select is high after a DAC frame.
- R9: MOSI is low whenever neither select is asserted.
- R10: Behaviour of `enable_i`:
  - While `enable_i` is low in idle, no frame starts.
  - Dropping `enable_i` lets the current frame finish, then both selects stay high and SCLK stays low. No further frame follows, so a stop during an ADC frame produces no DAC frame.
  - Raising `enable_i` again begins with an ADC frame.
- R11: Asserting `rst_ni` low immediately drives both selects high, SCLK low and MOSI low, without waiting for a clock edge. `sample_o` and both strobes read zero while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the follower loop |
| miso_i | input | 1 | Shared serial data from the selected device |
| sclk_o | output | 1 | Shared SPI clock, idle low |
| mosi_o | output | 1 | Shared serial data to the devices |
| adc_cs_no | output | 1 | ADC select, active low |
| dac_cs_no | output | 1 | DAC select, active low |
| sample_o | output | ADC_W | Last sample read from the ADC |
| sample_valid_o | output | 1 | One-cycle strobe: new sample available |
| dac_done_o | output | 1 | One-cycle strobe: DAC frame completed |

## Verification
Every result is due at a fixed distance from a bus event:
- the first SCLK rise comes CLK_DIV/2 cycles after a select falls;
- later rises within a frame follow every CLK_DIV cycles;
- both strobes arrive in the very cycle the owning select returns high;
- the next select may fall only after GAP_CLKS*CLK_DIV cycles with both selects high.

The bench samples all ports once per cycle, on the falling system-clock edge. At each sample it compares these distances against a cycle counter and tallies any frame whose bit count or spacing is off. A device model pushes each sample it serves into expected-value queues. A monitor pops an entry when `sample_valid_o` rises and when the DAC select rises, and compares it against the MOSI bits captured on each rising SCLK edge.

// File: rtl/spi_follower_pkg.sv
package spi_follower_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADC,
    ST_GAP_AD,
    ST_DAC,
    ST_GAP_DA
  } phase_e;
endpackage

// File: rtl/spi_follower_tick.sv
module spi_follower_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_follower_seq.sv
module spi_follower_seq
  import spi_follower_pkg::*;
#(
  parameter int ADC_W    = 16,
  parameter int DAC_W    = 24,
  parameter int GAP_CLKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic tick_i,
  output logic run_o,
  output logic sclk_o,
  output logic adc_cs_no,
  output logic dac_cs_no,
  output logic rise_o,
  output logic fall_o,
  output logic adc_end_o,
  output logic dac_end_o,
  output logic dac_load_o
);
  localparam int MAXW  = (ADC_W > DAC_W) ? ADC_W : DAC_W;
  localparam int BW    = $clog2(MAXW);
  localparam int GHALF = 2 * GAP_CLKS;
  localparam int GW    = $clog2(GHALF);

  phase_e        st_q;
  logic          sclk_q;
  logic [BW-1:0] bit_q;
  logic [GW-1:0] gap_q;
  logic          xfer, in_gap, last_bit, frame_end, gap_end;
  int            frame_len;

  always_comb begin
    frame_len = (st_q == ST_ADC) ? ADC_W : DAC_W;
    xfer      = (st_q == ST_ADC) || (st_q == ST_DAC);
    in_gap    = (st_q == ST_GAP_AD) || (st_q == ST_GAP_DA);
    last_bit  = (bit_q == BW'(frame_len - 1));
  end

  assign rise_o     = xfer && tick_i && !sclk_q;
  assign fall_o     = xfer && tick_i && sclk_q;
  assign frame_end  = fall_o && last_bit;
  assign adc_end_o  = frame_end && (st_q == ST_ADC);
  assign dac_end_o  = frame_end && (st_q == ST_DAC);
  assign gap_end    = in_gap && tick_i && (gap_q == GW'(GHALF - 1));
  assign dac_load_o = gap_end && (st_q == ST_GAP_AD) && enable_i;

  assign run_o     = (st_q != ST_IDLE);
  assign sclk_o    = sclk_q;
  assign adc_cs_no = (st_q != ST_ADC);
  assign dac_cs_no = (st_q != ST_DAC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      gap_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          bit_q <= '0;
          if (enable_i) st_q <= ST_ADC;
        end
        ST_ADC, ST_DAC: begin
          if (rise_o) sclk_q <= 1'b1;
          if (fall_o) begin
            sclk_q <= 1'b0;
            if (last_bit) begin
              st_q  <= (st_q == ST_ADC) ? ST_GAP_AD : ST_GAP_DA;
              gap_q <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_GAP_AD, ST_GAP_DA: begin
          if (gap_end) begin
            bit_q <= '0;
            if (!enable_i)              st_q <= ST_IDLE;
            else if (st_q == ST_GAP_AD) st_q <= ST_DAC;
            else                        st_q <= ST_ADC;
          end else if (tick_i) begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // SCLK moves only on divider ticks (R3)
  p_sclk_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sclk_q));
  // Turnaround keeps SCLK parked low (R4)
  p_gap_sclk_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_gap |-> !sclk_q);
endmodule

// File: rtl/spi_follower_data.sv
module spi_follower_data #(
  parameter int ADC_W = 16,
  parameter int DAC_W = 24,
  parameter logic [DAC_W-ADC_W-1:0] DAC_CMD = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miso_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             adc_sel_i,
  input  logic             dac_sel_i,
  input  logic             adc_end_i,
  input  logic             dac_end_i,
  input  logic             dac_load_i,
  output logic             mosi_o,
  output logic [ADC_W-1:0] sample_o,
  output logic             sample_valid_o,
  output logic             dac_done_o
);
  logic [ADC_W-1:0] adc_sr_q, sample_q;
  logic [DAC_W-1:0] dac_sr_q;
  logic             valid_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_sr_q <= '0;
      sample_q <= '0;
      dac_sr_q <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      valid_q <= adc_end_i;
      done_q  <= dac_end_i;
      if (rise_i && adc_sel_i) adc_sr_q <= {adc_sr_q[ADC_W-2:0], miso_i};
      if (adc_end_i)           sample_q <= adc_sr_q;
      if (dac_load_i)          dac_sr_q <= {DAC_CMD, sample_q};
      else if (fall_i && dac_sel_i)
        dac_sr_q <= {dac_sr_q[DAC_W-2:0], 1'b0};
    end
  end

  assign mosi_o         = dac_sel_i & dac_sr_q[DAC_W-1];
  assign sample_o       = sample_q;
  assign sample_valid_o = valid_q;
  assign dac_done_o     = done_q;

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/spi_follower.sv
module spi_follower #(
  parameter int CLK_DIV  = 4,
  parameter int ADC_W    = 16,
  parameter int DAC_W    = 24,
  parameter int GAP_CLKS = 1,
  parameter logic [DAC_W-ADC_W-1:0] DAC_CMD = 8'h30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             adc_cs_no,
  output logic             dac_cs_no,
  output logic [ADC_W-1:0] sample_o,
  output logic             sample_valid_o,
  output logic             dac_done_o
);
  localparam int HALF    = CLK_DIV / 2;
  localparam int GAP_SYS = GAP_CLKS * CLK_DIV;
  localparam int GCW     = $clog2(GAP_SYS + 1);

  logic run, tick, rise, fall, adc_end, dac_end, dac_load;

  spi_follower_tick #(.HALF(HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  spi_follower_seq #(.ADC_W(ADC_W), .DAC_W(DAC_W), .GAP_CLKS(GAP_CLKS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .tick_i     (tick),
    .run_o      (run),
    .sclk_o     (sclk_o),
    .adc_cs_no  (adc_cs_no),
    .dac_cs_no  (dac_cs_no),
    .rise_o     (rise),
    .fall_o     (fall),
    .adc_end_o  (adc_end),
    .dac_end_o  (dac_end),
    .dac_load_o (dac_load)
  );

  spi_follower_data #(.ADC_W(ADC_W), .DAC_W(DAC_W), .DAC_CMD(DAC_CMD)) u_data (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .miso_i         (miso_i),
    .rise_i         (rise),
    .fall_i         (fall),
    .adc_sel_i      (!adc_cs_no),
    .dac_sel_i      (!dac_cs_no),
    .adc_end_i      (adc_end),
    .dac_end_i      (dac_end),
    .dac_load_i     (dac_load),
    .mosi_o         (mosi_o),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o),
    .dac_done_o     (dac_done_o)
  );

  // Turnaround window checker: cycles with both selects high, saturating
  logic [GCW-1:0] idle_cnt_q;
  logic           both_hi;
  assign both_hi = adc_cs_no && dac_cs_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         idle_cnt_q <= GCW'(GAP_SYS);
    else if (!both_hi)                   idle_cnt_q <= '0;
    else if (idle_cnt_q != GCW'(GAP_SYS)) idle_cnt_q <= idle_cnt_q + 1'b1;
  end

  p_handoff_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adc_cs_no) || $fell(dac_cs_no)) |-> (idle_cnt_q == GCW'(GAP_SYS)));
  p_one_select_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no || dac_cs_no);
  p_idle_sclk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_hi |-> !sclk_o);
  p_mosi_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_hi |-> !mosi_o);
  p_valid_owner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> adc_cs_no);
endmodule

// File: tb/spi_follower_bench.sv
module spi_follower_bench;
  localparam int CLK_DIV  = 4;
  localparam int HALF     = CLK_DIV / 2;
  localparam int ADC_W    = 16;
  localparam int DAC_W    = 24;
  localparam int GAP_CLKS = 2;
  localparam logic [7:0] CMD = 8'h30;

  logic clk, rst_n, enable, miso;
  logic sclk, mosi, adc_cs_n, dac_cs_n, sample_valid, dac_done;
  logic [ADC_W-1:0] sample;

  spi_follower #(.CLK_DIV(CLK_DIV), .ADC_W(ADC_W), .DAC_W(DAC_W),
                 .GAP_CLKS(GAP_CLKS), .DAC_CMD(CMD)) u_spi_follower (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .miso_i(miso),
    .sclk_o(sclk), .mosi_o(mosi), .adc_cs_no(adc_cs_n), .dac_cs_no(dac_cs_n),
    .sample_o(sample), .sample_valid_o(sample_valid), .dac_done_o(dac_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Scoreboard queues
  logic [ADC_W-1:0] exp_smp_q[$];
  logic [DAC_W-1:0] exp_dac_q[$];
  int gen_k = 0;

  function automatic logic [ADC_W-1:0] gen_sample(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h0001;
      default: return 16'(k * 32'h9E37) ^ 16'h5A5A;
    endcase
  endfunction

  task automatic push_expected(output logic [ADC_W-1:0] s);
    s = gen_sample(gen_k);
    gen_k++;
    exp_smp_q.push_back(s);
    exp_dac_q.push_back({CMD, s});
  endtask

  // ADC device model: MSB on select fall, next bit after each SCLK fall
  initial begin
    logic [ADC_W-1:0] s;
    miso = 1'b0;
    forever begin
      @(negedge adc_cs_n);
      push_expected(s);
      #1 miso = s[ADC_W-1];
      for (int i = ADC_W - 2; i >= 0; i--) begin
        @(negedge sclk or posedge adc_cs_n);
        if (adc_cs_n) break;
        #1 miso = s[i];
      end
    end
  end

  // Per-cycle monitor
  int cyc = 0, n_adc = 0, n_dac = 0, n_rise = 0;
  int v_order = 0, v_both = 0, v_period = 0, v_first = 0, v_gap = 0;
  int v_idle_sclk = 0, v_bits_adc = 0, v_bits_dac = 0, v_valid = 0;
  int v_done = 0, v_mosi = 0;
  int idle_run = 1000, fall_cyc = 0, last_rise = 0, nbits = 0, last_dev = 0;
  bit first_rise = 1'b0;
  logic prev_a = 1'b1, prev_d = 1'b1, prev_sclk = 1'b0;
  logic [DAC_W-1:0] dac_word = '0;

  always @(negedge clk) begin
    logic both_hi, fell_a, fell_d, rose_a, rose_d;
    logic [DAC_W-1:0] e_d;
    logic [ADC_W-1:0] e_s;
    cyc++;
    if (!rst_n) begin
      idle_run = 1000; nbits = 0; last_dev = 0; dac_word = '0;
      prev_a = adc_cs_n; prev_d = dac_cs_n; prev_sclk = sclk;
    end else begin
      both_hi = adc_cs_n && dac_cs_n;
      fell_a = prev_a && !adc_cs_n;  fell_d = prev_d && !dac_cs_n;
      rose_a = !prev_a && adc_cs_n;  rose_d = !prev_d && dac_cs_n;
      if (!adc_cs_n && !dac_cs_n) v_both++;
      if (both_hi && sclk) v_idle_sclk++;
      if (both_hi && mosi) v_mosi++;
      if (fell_a || fell_d) begin
        if (idle_run < GAP_CLKS * CLK_DIV) v_gap++;
        if (fell_d && last_dev != 1) v_order++;
        last_dev = fell_a ? 1 : 2;
        nbits = 0; fall_cyc = cyc; first_rise = 1'b1; dac_word = '0;
      end
      if (both_hi) idle_run++; else idle_run = 0;
      if (sclk && !prev_sclk) begin
        n_rise++;
        if (!both_hi) begin
          if (first_rise) begin
            if (cyc - fall_cyc != HALF) v_first++;
          end else if (cyc - last_rise != CLK_DIV) v_period++;
          first_rise = 1'b0;
          last_rise = cyc;
          nbits++;
          if (!dac_cs_n) dac_word = {dac_word[DAC_W-2:0], mosi};
        end
      end
      if (rose_a) begin
        n_adc++;
        if (nbits != ADC_W) v_bits_adc++;
      end
      if (rose_d) begin
        n_dac++;
        if (nbits != DAC_W) v_bits_dac++;
        if (exp_dac_q.size() == 0) check(1'b0, "R6 unexpected DAC frame", dac_word, 0);
        else begin
          e_d = exp_dac_q.pop_front();
          check(dac_word == e_d, "R6 DAC word", dac_word, e_d);
        end
      end
      if (sample_valid != rose_a) v_valid++;
      if (dac_done != rose_d) v_done++;
      if (sample_valid) begin
        if (exp_smp_q.size() == 0) check(1'b0, "R5 unexpected sample", sample, 0);
        else begin
          e_s = exp_smp_q.pop_front();
          check(sample == e_s, "R5 sample_o", sample, e_s);
        end
      end
      prev_a = adc_cs_n; prev_d = dac_cs_n; prev_sclk = sclk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  task automatic wait_dac(input int target);
    while (n_dac < target) @(negedge clk);
  endtask

  initial begin
    int base, r, a0, d0;
    rst_n = 1'b0; enable = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(adc_cs_n && dac_cs_n, "R11 selects high in reset", {adc_cs_n, dac_cs_n}, 2'b11);
    check(!sclk && !mosi, "R11 sclk/mosi low in reset", {sclk, mosi}, 0);
    check(sample == '0, "R11 sample zero", sample, 0);
    check(!sample_valid && !dac_done, "R11 strobes low", {sample_valid, dac_done}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(n_rise == 0 && adc_cs_n && dac_cs_n, "R10 idle while disabled", n_rise, 0);

    // R1 R5 R6 main loop
    enable = 1'b1;
    wait_dac(6);

    // R10 stop during a DAC frame
    while (dac_cs_n) @(negedge clk);
    enable = 1'b0;
    base = n_dac;
    wait_dac(base + 1);
    r = n_rise;
    repeat (200) @(negedge clk);
    check(n_rise == r, "R10 no SCLK after stop", n_rise, r);
    check(adc_cs_n && dac_cs_n, "R10 selects high after stop", {adc_cs_n, dac_cs_n}, 2'b11);
    check(n_dac == base + 1, "R10 DAC frame finished", n_dac, base + 1);

    // R10 stop during an ADC frame
    enable = 1'b1;
    wait_dac(n_dac + 3);
    while (adc_cs_n) @(negedge clk);
    enable = 1'b0;
    a0 = n_adc; d0 = n_dac;
    while (n_adc < a0 + 1) @(negedge clk);
    repeat (200) @(negedge clk);
    check(n_dac == d0, "R10 no DAC frame after stop in ADC", n_dac, d0);
    check(exp_dac_q.size() == 1, "R10 one unwritten sample", exp_dac_q.size(), 1);
    exp_dac_q.delete();

    // R10 restart begins with ADC
    enable = 1'b1;
    while (adc_cs_n && dac_cs_n) @(negedge clk);
    check(!adc_cs_n, "R10 restart with ADC frame", adc_cs_n, 0);
    wait_dac(n_dac + 3);

    // R11 asynchronous reset mid DAC frame
    while (dac_cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    check(adc_cs_n && dac_cs_n && !sclk && !mosi, "R11 async reset idles bus",
          {adc_cs_n, dac_cs_n, sclk, mosi}, 4'b1100);
    exp_dac_q.delete();
    exp_smp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_dac(n_dac + 3);
    repeat (5) @(negedge clk);

    check(v_order == 0, "R1 ADC precedes DAC", v_order, 0);
    check(v_both == 0, "R2 single select", v_both, 0);
    check(v_period == 0, "R3 SCLK period", v_period, 0);
    check(v_first == 0, "R3 select to first edge", v_first, 0);
    check(v_gap == 0, "R4 turnaround length", v_gap, 0);
    check(v_idle_sclk == 0, "R4 SCLK low when deselected", v_idle_sclk, 0);
    check(v_bits_adc == 0, "R5 ADC frame length", v_bits_adc, 0);
    check(v_bits_dac == 0, "R6 DAC frame length", v_bits_dac, 0);
    check(v_valid == 0, "R7 sample_valid timing", v_valid, 0);
    check(v_done == 0, "R8 dac_done timing", v_done, 0);
    check(v_mosi == 0, "R9 MOSI low when deselected", v_mosi, 0);
    summary();
    $finish;
  end
endmodule